// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs a 12-bit converter that has a parallel output bus and a three-wire handshake: an active-low chip select, an active-low read/convert line, and a busy line that the converter drives. A conversion starts when the host pulses its start request, or on a fixed cycle period when automatic sampling is enabled. The sequencer first lowers chip select. After a setup time it lowers read/convert for a pulse of at least the minimum width. It then waits for busy to fall and rise again. When busy rises, the sequencer reads the two's complement word from the bus and offers it downstream.

The converter treats chip select and read/convert as a level-triggered OR. Read/convert is always the triggering input, so chip select is lowered a parameterised number of cycles ahead of it. The converter ignores commands while busy is low. For that reason the sequencer never drops read/convert unless its synchronised copy of busy is high. Consecutive convert edges are spaced by at least the acquisition gap, which is a parameter in nanoseconds rounded up to clock cycles. If busy does not fall, or does not rise again, within its own cycle budget, the sequence is abandoned and a one-cycle error strobe is raised.

The result leaves the block on a valid/ready stream. The stream carries the raw 12-bit code and a 16-bit sign-extended copy. Back-pressure rules: once `res_valid` is raised, it stays high with unchanged data until a cycle in which `res_ready` is high. No new conversion is launched while a result is waiting, so a stalled consumer delays sampling instead of losing words. If `res_ready` is held high, every result is a single-cycle strobe.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `conv_cs_n` and `conv_rc_n` are high, and `res_valid` and `tmo_err` are low.
- R2: Each convert command holds `conv_rc_n` low for exactly PULSE_CYC cycles. PULSE_CYC is PULSE_NS divided by CLK_PERIOD_NS, rounded up, with a minimum of 1; it is 2 at the defaults (40 ns, 20 ns). Throughout that pulse, `conv_cs_n` is low.
- R3: `conv_cs_n` is low for at least SETUP_CYC cycles before `conv_rc_n` falls, and `conv_rc_n` is never low while `conv_cs_n` is high. SETUP_CYC is 1 at the defaults.
- R4: `conv_rc_n` never falls while the synchronised busy is low, and the converter sees no command while its busy is low. A start request that arrives during a sequence is remembered (one deep) and served once the sequence ends.
- R5: Two falling edges of `conv_rc_n` are always at least GAP_CYC cycles apart. GAP_CYC is 1250 ns rounded up to 63 cycles at a 20 ns clock. When requests are made faster than this, the spacing is exactly GAP_CYC.
- R6: On the first synchronised high of busy after it has fallen, the word on `conv_data` is captured while `conv_cs_n` is low and `conv_rc_n` is high. `res_code` equals that word, with bit 11 as the sign bit.
- R7: `res_valid` stays high and `res_code`/`res_ext` stay unchanged until `res_ready` is high. It clears in the cycle after acceptance. While a result is pending, no convert command is issued. With `res_ready` held high, `res_valid` lasts one cycle.
- R8: `res_ext` is `res_code` sign-extended to 16 bits: 0x7FF→0x07FF, 0x800→0xF800, 0xFFF→0xFFFF, 0x000→0x0000.
- R9: With `auto_en` high and `rate_period` = N > 0, a request is made every N cycles. When N ≥ GAP_CYC and the conversion ends within N, convert edges are exactly N cycles apart.
- R10: If synchronised busy is not low within BUSY_FALL_TMO cycles of the end of the convert pulse, `tmo_err` pulses for one cycle, `conv_cs_n` returns high, no result is produced, and later conversions work normally.
- R11: If synchronised busy does not return high within BUSY_RISE_TMO cycles of falling, `tmo_err` pulses for one cycle, `conv_cs_n` returns high, and no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | One-cycle request for a conversion |
| auto_en | input | 1 | Enables periodic requests |
| rate_period | input | 16 | Period of automatic requests in cycles (0 disables) |
| conv_cs_n | output | 1 | Converter chip select, active low |
| conv_rc_n | output | 1 | Converter read/convert; low starts a conversion |
| conv_busy | input | 1 | Converter busy, low while converting (asynchronous) |
| conv_data | input | 12 | Converter parallel data bus, two's complement |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_code | output | 12 | Raw two's complement result |
| res_ext | output | 16 | Sign-extended result |
| tmo_err | output | 1 | One-cycle strobe when a busy phase times out |

## Verification
The assertions assume two things about the converter. First, its busy line falls only in response to a convert edge. Second, it raises busy only after its output word is stable on the bus. The capture check depends on both. They also assume that `start_req`, `auto_en` and `rate_period` are synchronous to `clk`. The bench stub follows these assumptions: it loads the new word into its register in the same cycle it raises busy, and the design samples the bus only after two synchroniser stages. When the bus is not enabled, the stub drives the bitwise inverse of the word, so a read made at the wrong moment shows up as a wrong code. Stimulus changes only on falling clock edges. The rate is changed only after several conversions have completed at the previous rate.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_WFALL,
    ST_WRISE
  } seq_state_t;

  // Round a duration in ns up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int dur_ns, input int period_ns);
    int c;
    c = (dur_ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adc_seq_trigger.sv
module adc_seq_trigger #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              auto_en,
  input  logic [RATE_W-1:0] rate_period,
  input  logic              take,
  output logic              pending
);
  logic [RATE_W-1:0] rate_cnt_q;
  logic              tick;
  logic              rate_on;

  assign rate_on = auto_en && (rate_period != '0);
  assign tick    = rate_on && (rate_cnt_q >= rate_period - RATE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_cnt_q <= '0;
    end else if (!rate_on || tick) begin
      rate_cnt_q <= '0;
    end else begin
      rate_cnt_q <= rate_cnt_q + RATE_W'(1);
    end
  end

  // One-deep request memory; a fresh request wins over a same-cycle take.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending && !take) || start_req || tick;
  end
endmodule

// File: rtl/adc_seq_gap.sv
module adc_seq_gap #(
  parameter int GAP_CYC = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic gap_ok
);
  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= LAST;
    else if (load)        cnt_q <= '0;
    else if (cnt_q < LAST) cnt_q <= cnt_q + CW'(1);
  end

  assign gap_ok = (cnt_q >= LAST);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int PULSE_NS      = 40,
  parameter int SETUP_NS      = 10,
  parameter int GAP_NS        = 1250,
  parameter int BUSY_FALL_TMO = 16,
  parameter int BUSY_RISE_TMO = 64,
  parameter int DATA_W        = 12,
  parameter int EXT_W         = 16,
  parameter int RATE_W        = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              auto_en,
  input  logic [RATE_W-1:0] rate_period,
  output logic              conv_cs_n,
  output logic              conv_rc_n,
  input  logic              conv_busy,
  input  logic [DATA_W-1:0] conv_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_code,
  output logic [EXT_W-1:0]  res_ext,
  output logic              tmo_err
);
  localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_PERIOD_NS);
  localparam int SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_PERIOD_NS);
  localparam int GAP_CYC   = ns_to_cycles(GAP_NS, CLK_PERIOD_NS);
  localparam int MAX_A     = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B     = (BUSY_FALL_TMO > BUSY_RISE_TMO) ? BUSY_FALL_TMO : BUSY_RISE_TMO;
  localparam int PH_MAX    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PH_W      = $clog2(PH_MAX + 1);
  localparam int PAD_W     = EXT_W - DATA_W;

  localparam logic [PH_W-1:0] SETUP_LAST = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0] PULSE_LAST = PH_W'(PULSE_CYC - 1);
  localparam logic [PH_W-1:0] FALL_LAST  = PH_W'(BUSY_FALL_TMO - 1);
  localparam logic [PH_W-1:0] RISE_LAST  = PH_W'(BUSY_RISE_TMO - 1);
  localparam logic [PH_W-1:0] PH_TOP     = PH_W'(PH_MAX);

  logic            busy_s;
  logic            pending;
  logic            take;
  logic            gap_ok;
  logic            gap_load;
  logic            ph_clr;
  logic            tmo_d;
  logic            capture;
  seq_state_t      state_q, state_d;
  logic [PH_W-1:0] ph_q;

  logic              valid_q;
  logic [DATA_W-1:0] code_q;
  logic [EXT_W-1:0]  ext_q;
  logic              tmo_q;

  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (conv_busy),
    .q     (busy_s)
  );

  adc_seq_trigger #(.RATE_W(RATE_W)) u_trigger (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .auto_en     (auto_en),
    .rate_period (rate_period),
    .take        (take),
    .pending     (pending)
  );

  adc_seq_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (gap_load),
    .gap_ok (gap_ok)
  );

  // Sequencing: select, setup, convert pulse, busy low, busy high.
  always_comb begin
    state_d  = state_q;
    ph_clr   = 1'b0;
    take     = 1'b0;
    gap_load = 1'b0;
    tmo_d    = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pending && busy_s && !valid_q) begin
          take    = 1'b1;
          state_d = ST_SETUP;
          ph_clr  = 1'b1;
        end
      end
      ST_SETUP: begin
        if ((ph_q >= SETUP_LAST) && gap_ok) begin
          state_d  = ST_PULSE;
          ph_clr   = 1'b1;
          gap_load = 1'b1;
        end
      end
      ST_PULSE: begin
        if (ph_q == PULSE_LAST) begin
          state_d = ST_WFALL;
          ph_clr  = 1'b1;
        end
      end
      ST_WFALL: begin
        if (!busy_s) begin
          state_d = ST_WRISE;
          ph_clr  = 1'b1;
        end else if (ph_q == FALL_LAST) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end
      end
      ST_WRISE: begin
        if (busy_s) begin
          state_d = ST_IDLE;
          capture = 1'b1;
        end else if (ph_q == RISE_LAST) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
      if (ph_clr)              ph_q <= '0;
      else if (ph_q != PH_TOP) ph_q <= ph_q + PH_W'(1);
    end
  end

  // Result stage: hold until accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      ext_q   <= '0;
    end else if (capture) begin
      valid_q <= 1'b1;
      code_q  <= conv_data;
      ext_q   <= {{PAD_W{conv_data[DATA_W-1]}}, conv_data};
    end else if (valid_q && res_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign conv_cs_n = (state_q == ST_IDLE);
  assign conv_rc_n = (state_q != ST_PULSE);
  assign res_valid = valid_q;
  assign res_code  = code_q;
  assign res_ext   = ext_q;
  assign tmo_err   = tmo_q;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int PULSE_CYC = 2,
  parameter int SETUP_CYC = 1,
  parameter int GAP_CYC   = 63,
  parameter int DATA_W    = 12,
  parameter int EXT_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_cs_n,
  input logic              conv_rc_n,
  input logic              busy_s,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_code,
  input logic [EXT_W-1:0]  res_ext
);
  logic [15:0] rc_run, cs_run, gap_cnt;
  logic        rc_prev;
  logic        rc_fell;

  assign rc_fell = !conv_rc_n && rc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_run  <= '0;
      cs_run  <= '0;
      gap_cnt <= 16'(GAP_CYC);
      rc_prev <= 1'b1;
    end else begin
      rc_prev <= conv_rc_n;
      if (!conv_rc_n && rc_run != 16'hFFFF) rc_run <= rc_run + 16'd1;
      else if (conv_rc_n)                   rc_run <= '0;
      if (!conv_cs_n && cs_run != 16'hFFFF) cs_run <= cs_run + 16'd1;
      else if (conv_cs_n)                   cs_run <= '0;
      if (rc_fell)                          gap_cnt <= 16'd1;
      else if (gap_cnt < 16'(GAP_CYC))      gap_cnt <= gap_cnt + 16'd1;
    end
  end

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_rc_n && !rc_prev) |-> (rc_run == 16'(PULSE_CYC)));

  assert_setup_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rc_fell |-> (cs_run >= 16'(SETUP_CYC)));

  assert_rc_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_rc_n |-> !conv_cs_n);

  assert_no_cmd_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rc_fell |-> busy_s);

  assert_min_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rc_fell |-> (gap_cnt >= 16'(GAP_CYC)));

  assert_hold_until_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) && $stable(res_ext)));

  assert_no_cmd_while_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !rc_fell);

  assert_sign_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_ext[DATA_W-1:0] == res_code) &&
                   (res_ext[EXT_W-1:DATA_W] == {(EXT_W-DATA_W){res_code[DATA_W-1]}})));
endmodule

bind adc_conv_seq adc_seq_checker #(
  .PULSE_CYC (PULSE_CYC),
  .SETUP_CYC (SETUP_CYC),
  .GAP_CYC   (GAP_CYC),
  .DATA_W    (DATA_W),
  .EXT_W     (EXT_W)
) u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_cs_n (conv_cs_n),
  .conv_rc_n (conv_rc_n),
  .busy_s    (busy_s),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_code  (res_code),
  .res_ext   (res_ext)
);

// File: tb/adc_conv_seq_test.sv
`timescale 1ns/1ps
module adc_conv_seq_test;
  localparam int CONV_LEN = 20;
  localparam int GAP_EXP  = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic        auto_en = 1'b0;
  logic [15:0] rate_period = 16'd0;
  logic        conv_cs_n, conv_rc_n;
  logic        conv_busy;
  logic [11:0] conv_data;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [11:0] res_code;
  logic [15:0] res_ext;
  logic        tmo_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_conv_seq uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .auto_en(auto_en),
    .rate_period(rate_period), .conv_cs_n(conv_cs_n), .conv_rc_n(conv_rc_n),
    .conv_busy(conv_busy), .conv_data(conv_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_code(res_code), .res_ext(res_ext), .tmo_err(tmo_err)
  );

  // Converter stub. mode 0 normal, 1 ignores commands, 2 never ends.
  int          stub_mode = 0;
  logic [11:0] stub_code = 12'h000;
  logic [11:0] stub_reg = 12'h000;
  logic        stub_busy = 1'b1;
  logic        converting = 1'b0;
  int          stub_cnt = 0;
  int          cyc = 0;
  int          starts = 0;
  int          last_start = 0;
  int          spacing = 0;
  int          last_pw = 0;
  int          rc_run = 0;
  int          cs_run = 0;
  int          setup_seen = 0;
  int          viol = 0;
  logic        rc_prev = 1'b1;
  logic        cmd;

  assign conv_busy = stub_busy;
  assign conv_data = (!conv_cs_n && conv_rc_n && stub_busy) ? stub_reg : ~stub_reg;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rc_prev <= conv_rc_n;
    if (!conv_rc_n) rc_run <= rc_run + 1;
    else begin
      if (rc_run != 0) last_pw <= rc_run;
      rc_run <= 0;
    end
    if (!conv_cs_n) cs_run <= cs_run + 1; else cs_run <= 0;
    cmd = !conv_rc_n && rc_prev && !conv_cs_n;
    if (cmd) begin
      setup_seen <= cs_run;
      if (!stub_busy) viol <= viol + 1;
      else if (stub_mode != 1) begin
        starts <= starts + 1;
        if (starts > 0) spacing <= cyc - last_start;
        last_start <= cyc;
        stub_busy  <= 1'b0;
        converting <= (stub_mode == 0);
        stub_cnt   <= CONV_LEN;
      end
    end else if (converting) begin
      if (stub_cnt == 0) begin
        stub_reg   <= stub_code;
        stub_busy  <= 1'b1;
        converting <= 1'b0;
      end else stub_cnt <= stub_cnt - 1;
    end else if (stub_mode == 0 && !stub_busy) begin
      stub_busy <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic wait_result(output bit got, output logic [11:0] c, output logic [15:0] e, output int width);
    got = 0; c = '0; e = '0; width = 0;
    for (int k = 0; k < 800 && !got; k++) begin
      @(negedge clk);
      if (res_valid) begin got = 1; c = res_code; e = res_ext; end
    end
    if (got && res_ready) begin
      while (res_valid && width < 50) begin width++; @(negedge clk); end
    end
  endtask

  task automatic wait_starts(input int target);
    for (int k = 0; k < 3000 && starts < target; k++) @(negedge clk);
  endtask

  // code, expected sign-extended value
  localparam logic [27:0] VEC [6] = '{
    {12'h7FF, 16'h07FF}, {12'h000, 16'h0000}, {12'hFFF, 16'hFFFF},
    {12'h800, 16'hF800}, {12'h123, 16'h0123}, {12'hA5A, 16'hFA5A}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit got; logic [11:0] c; logic [15:0] e; int w; int s0; int nres; bit stable; bit seen_err; bit seen_val; int errw;

    repeat (3) @(negedge clk);
    chk(conv_cs_n == 1'b1, "R1 cs_n after reset", 32'(conv_cs_n), 1);
    chk(conv_rc_n == 1'b1, "R1 rc_n after reset", 32'(conv_rc_n), 1);
    chk(res_valid == 1'b0, "R1 valid after reset", 32'(res_valid), 0);
    chk(tmo_err == 1'b0,   "R1 tmo after reset",   32'(tmo_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Vector walk
    foreach (VEC[i]) begin
      stub_code = VEC[i][27:16];
      pulse_start();
      wait_result(got, c, e, w);
      chk(got, "R6 result arrives", 32'(got), 1);
      chk(c == VEC[i][27:16], "R6 raw code", 32'(c), 32'(VEC[i][27:16]));
      chk(e == VEC[i][15:0], "R8 sign extension", 32'(e), 32'(VEC[i][15:0]));
      chk(w == 1, "R7 one-cycle strobe with ready high", 32'(w), 1);
      chk(last_pw == 2, "R2 convert pulse width", 32'(last_pw), 2);
      chk(setup_seen >= 1, "R3 select leads convert", 32'(setup_seen), 1);
      chk(viol == 0, "R4 no command during busy", 32'(viol), 0);
    end

    // R4: request during a running sequence is held and served
    stub_code = 12'h155;
    repeat (80) @(negedge clk);
    s0 = starts; nres = 0;
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (res_valid) nres++;
    end
    chk(nres == 2, "R4 held request served once", 32'(nres), 2);
    chk(starts == s0 + 2, "R4 converter start count", 32'(starts - s0), 2);

    // R7: back-pressure
    res_ready = 1'b0;
    stub_code = 12'h3C3;
    pulse_start();
    wait_result(got, c, e, w);
    chk(got && c == 12'h3C3, "R7 stalled result code", 32'(c), 32'h3C3);
    stub_code = 12'h0F0;
    s0 = starts; stable = 1;
    start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!res_valid || res_code != 12'h3C3 || res_ext != 16'h03C3) stable = 0;
    end
    chk(stable, "R7 valid and data held while not ready", 32'(stable), 1);
    chk(starts == s0, "R7 no convert while result pending", 32'(starts - s0), 0);
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 valid clears after acceptance", 32'(res_valid), 0);
    wait_result(got, c, e, w);
    chk(got && c == 12'h0F0, "R4 request held across stall", 32'(c), 32'h0F0);

    // R5: fast automatic requests are spaced by the acquisition gap
    repeat (80) @(negedge clk);
    stub_code = 12'h444;
    rate_period = 16'd10; auto_en = 1'b1;
    s0 = starts;
    wait_starts(s0 + 3);
    chk(spacing == GAP_EXP, "R5 spacing equals gap", 32'(spacing), GAP_EXP);
    chk(viol == 0, "R4 no command during busy in auto mode", 32'(viol), 0);

    // R9: slow automatic rate sets the spacing
    rate_period = 16'd150;
    s0 = starts;
    wait_starts(s0 + 3);
    chk(spacing == 150, "R9 spacing equals rate period", 32'(spacing), 150);
    auto_en = 1'b0;
    repeat (400) @(negedge clk);

    // R10: busy never falls
    stub_mode = 1; seen_err = 0; seen_val = 0; errw = 0;
    pulse_start();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (tmo_err) begin seen_err = 1; errw++; end
      if (res_valid) seen_val = 1;
    end
    chk(seen_err && errw == 1, "R10 one-cycle timeout strobe", 32'(errw), 1);
    chk(!seen_val, "R10 no result after timeout", 32'(seen_val), 0);
    chk(conv_cs_n == 1'b1, "R10 select released", 32'(conv_cs_n), 1);

    // R11: busy never rises
    stub_mode = 2; seen_err = 0; seen_val = 0; errw = 0;
    pulse_start();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (tmo_err) begin seen_err = 1; errw++; end
      if (res_valid) seen_val = 1;
    end
    chk(seen_err && errw == 1, "R11 one-cycle timeout strobe", 32'(errw), 1);
    chk(!seen_val, "R11 no result after timeout", 32'(seen_val), 0);
    chk(conv_cs_n == 1'b1, "R11 select released", 32'(conv_cs_n), 1);

    // Recovery
    stub_mode = 0;
    repeat (20) @(negedge clk);
    stub_code = 12'h2AA;
    pulse_start();
    wait_result(got, c, e, w);
    chk(got && c == 12'h2AA, "R10 normal conversion after timeouts", 32'(c), 32'h2AA);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule